// File: doc/BRIEF.md
# 32-Pin GPIO Port with Interrupt Detection

The block is a general-purpose I/O port of 32 pins controlled through a small register interface. The interface has a word address, write data, write strobe, read strobe and registered read data. Every access completes in the cycle it is presented. The interface has no back-pressure and no valid/ready handshake, because the port never stalls.

Software keeps an output value and a per-pin direction. It can change output bits atomically through set, clear and toggle aliases. It reads the pad pins back through a two-flop synchronizer.

Each pin can flag an event on one of four conditions: low level, high level, rising edge or falling edge. A per-pin any-edge override makes the pin flag on both edges instead. Events latch into a sticky status register that is cleared by writing ones. Status bits that are enabled in a mask register drive a single interrupt line.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register reads zero, `pad_oe` and `pad_out` are all zero, and `irq` is low.
- R2: Address 0 holds the output value, which is written directly and read back unchanged. `pad_out` always equals this value. Read data appears on `rdata` in the cycle after the one in which `re` is sampled.
- R3: Writing a mask to address 1 ORs it into the output value. Writing a mask to address 2 clears the masked bits. Writing a mask to address 3 inverts the masked bits. Bits outside the mask keep their value.
- R4: Address 4 holds the direction. A 1 in a bit makes `pad_oe` for that pin 1, so the pin drives its output bit. A 0 makes the pin an input.
- R5: Address 5 reads the pad inputs after a two-flop synchronizer, whatever the direction. A read issued on the cycle after a pad change still returns the old value, and the read after that returns the new value.
- R6: Each pin has a 2-bit sense code: 0 means low level, 1 means high level, 2 means rising edge and 3 means falling edge. The codes for pins 0 to 15 sit in address 6 at bit 2*pin. The codes for pins 16 to 31 sit in address 7 at bit 2*(pin-16). An edge is found by comparing the synchronized pad value with its value one clock earlier.
- R7: When a pin's bit in address 8 is 1, that pin flags on both rising and falling edges, and its sense code has no effect.
- R8: Address 9 is the status register. A detected event sets its bit, and the bit stays set. Writing a 1 clears that bit, and writing a 0 leaves it unchanged.
- R9: In a level mode, the status bit is set again on every clock while the level holds, so a clear write does not leave the bit clear.
- R10: If a clear write and a new event hit the same status bit in the same cycle, the bit ends up set.
- R11: Address 10 is the interrupt mask. `irq` is high while any status bit is set and its mask bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register word address |
| wdata | input | 32 | Write data |
| we | input | 1 | Write strobe |
| re | input | 1 | Read strobe |
| rdata | output | 32 | Read data, registered |
| pad_in | input | 32 | Pad input levels, asynchronous |
| pad_out | output | 32 | Output value to the pads |
| pad_oe | output | 32 | Per-pin output enable |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest case to reach from the ports is a status-clear write that arrives in exactly the same clock as a freshly detected edge.

The bench reaches it by counting the registers on the path. A pad changes just after a falling clock edge. It passes two synchronizer flops and then the edge compare, which sets status on the third rising edge. The bench therefore waits one more falling edge and then issues the clear, so that its write strobe is sampled on that third rising edge.

The same counting is used to show that a pad read issued one cycle after a pad change still returns the old value.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_DATA  = 4'd0,
    A_SET   = 4'd1,
    A_CLR   = 4'd2,
    A_TGL   = 4'd3,
    A_DIR   = 4'd4,
    A_PAD   = 4'd5,
    A_SLO   = 4'd6,
    A_SHI   = 4'd7,
    A_BOTH  = 4'd8,
    A_STAT  = 4'd9,
    A_MASK  = 4'd10
  } gpio_reg_e;

  typedef enum logic [1:0] {
    SNS_LOW  = 2'd0,
    SNS_HIGH = 2'd1,
    SNS_RISE = 2'd2,
    SNS_FALL = 2'd3
  } gpio_sense_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/gpio_sense.sv
module gpio_sense
  import gpio_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   cur,
  input  logic [2*NPINS-1:0] sense_flat,
  input  logic [NPINS-1:0]   any_edge,
  output logic [NPINS-1:0]   evt
);

  logic [NPINS-1:0] prev_q;

  // one clock of history for edge comparison
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic        rise, fall;
    gpio_sense_e code;

    assign rise = cur[p] & ~prev_q[p];
    assign fall = ~cur[p] & prev_q[p];
    assign code = gpio_sense_e'(sense_flat[2*p +: 2]);

    always_comb begin
      if (any_edge[p]) begin
        evt[p] = rise | fall;
      end else begin
        unique case (code)
          SNS_LOW:  evt[p] = ~cur[p];
          SNS_HIGH: evt[p] = cur[p];
          SNS_RISE: evt[p] = rise;
          SNS_FALL: evt[p] = fall;
          default:  evt[p] = 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] pad_sync,
  input  logic [DATA_W-1:0] evt,
  output logic [DATA_W-1:0] data_q,
  output logic [DATA_W-1:0] dir_q,
  output logic [DATA_W-1:0] slo_q,
  output logic [DATA_W-1:0] shi_q,
  output logic [DATA_W-1:0] both_q,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] mask_q
);

  logic [DATA_W-1:0] stat_clr;
  logic [DATA_W-1:0] rd_mux;

  assign stat_clr = (we && addr == A_STAT) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      slo_q  <= '0;
      shi_q  <= '0;
      both_q <= '0;
      mask_q <= '0;
    end else if (we) begin
      case (addr)
        A_DATA: data_q <= wdata;
        A_SET:  data_q <= data_q | wdata;
        A_CLR:  data_q <= data_q & ~wdata;
        A_TGL:  data_q <= data_q ^ wdata;
        A_DIR:  dir_q  <= wdata;
        A_SLO:  slo_q  <= wdata;
        A_SHI:  shi_q  <= wdata;
        A_BOTH: both_q <= wdata;
        A_MASK: mask_q <= wdata;
        default: ;
      endcase
    end
  end

  // new events take priority over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~stat_clr) | evt;
  end

  always_comb begin
    case (addr)
      A_DATA, A_SET, A_CLR, A_TGL: rd_mux = data_q;
      A_DIR:   rd_mux = dir_q;
      A_PAD:   rd_mux = pad_sync;
      A_SLO:   rd_mux = slo_q;
      A_SHI:   rd_mux = shi_q;
      A_BOTH:  rd_mux = both_q;
      A_STAT:  rd_mux = stat_q;
      A_MASK:  rd_mux = mask_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= rd_mux;
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic [DATA_W-1:0] pad_oe,
  output logic              irq
);

  localparam int NPINS = DATA_W;

  logic [NPINS-1:0]   pad_sync;
  logic [NPINS-1:0]   evt;
  logic [DATA_W-1:0]  data_q, dir_q, slo_q, shi_q, both_q, stat_q, mask_q;
  logic [2*NPINS-1:0] sense_flat;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pad_sync)
  );

  // upper half of pins lives in the second sense register
  assign sense_flat = {shi_q, slo_q};

  gpio_sense #(.NPINS(NPINS)) u_sense (
    .clk        (clk),
    .rst_n      (rst_n),
    .cur        (pad_sync),
    .sense_flat (sense_flat),
    .any_edge   (both_q),
    .evt        (evt)
  );

  gpio_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wdata    (wdata),
    .we       (we),
    .re       (re),
    .rdata    (rdata),
    .pad_sync (pad_sync),
    .evt      (evt),
    .data_q   (data_q),
    .dir_q    (dir_q),
    .slo_q    (slo_q),
    .shi_q    (shi_q),
    .both_q   (both_q),
    .stat_q   (stat_q),
    .mask_q   (mask_q)
  );

  assign pad_out = data_q;
  assign pad_oe  = dir_q;
  assign irq     = |(stat_q & mask_q);

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              we,
  input logic [DATA_W-1:0] pad_out,
  input logic [DATA_W-1:0] pad_oe,
  input logic              irq,
  input logic [DATA_W-1:0] stat
);

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_SET) |=> pad_out == ($past(pad_out) | $past(wdata)));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_CLR) |=> pad_out == ($past(pad_out) & ~$past(wdata)));

  p_tgl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_TGL) |=> pad_out == ($past(pad_out) ^ $past(wdata)));

  p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == A_DIR) |=> $stable(pad_oe));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && addr == A_STAT) |=> ((stat & $past(stat)) == $past(stat)));

  p_mask_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_MASK && wdata == '0) |=> !irq);

endmodule

bind gpio_port gpio_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .addr    (addr),
  .wdata   (wdata),
  .we      (we),
  .pad_out (pad_out),
  .pad_oe  (pad_oe),
  .irq     (irq),
  .stat    (stat_q)
);

// File: tb/tb_gpio_port.sv
`timescale 1ns/1ps
module tb_gpio_port;
  import gpio_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic        re = 1'b0;
  logic [31:0] rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we), .re(re),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // fields: pin[10:6] sense[5:4] both[3] v0[2] v1[1] exp[0]
  localparam logic [10:0] VEC [12] = '{
    {5'd3,  2'd2, 1'b0, 1'b0, 1'b1, 1'b1},
    {5'd3,  2'd2, 1'b0, 1'b1, 1'b0, 1'b0},
    {5'd20, 2'd3, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd20, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0},
    {5'd7,  2'd1, 1'b0, 1'b0, 1'b1, 1'b1},
    {5'd7,  2'd1, 1'b0, 1'b0, 1'b0, 1'b0},
    {5'd28, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1},
    {5'd28, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0},
    {5'd12, 2'd2, 1'b1, 1'b1, 1'b0, 1'b1},
    {5'd17, 2'd3, 1'b1, 1'b0, 1'b1, 1'b1},
    {5'd31, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0},
    {5'd0,  2'd1, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input gpio_reg_e a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input gpio_reg_e a, output logic [31:0] d);
    @(negedge clk);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, m;
    settle(3);
    rst_n = 1'b1;
    settle(1);

    // R1 reset state
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    rd(A_DATA, r); check("R1 data", r, 32'h0);
    rd(A_DIR, r);  check("R1 dir", r, 32'h0);
    rd(A_MASK, r); check("R1 mask", r, 32'h0);

    // R2 data register
    m = 32'h1234_5678;
    wr(A_DATA, m);
    check("R2 pad_out", pad_out, m);
    rd(A_DATA, r); check("R2 readback", r, m);

    // R3 aliases
    wr(A_SET, 32'h0000_00F0); m = m | 32'h0000_00F0;
    check("R3 set", pad_out, m);
    wr(A_CLR, 32'h1200_0008); m = m & ~32'h1200_0008;
    check("R3 clear", pad_out, m);
    wr(A_TGL, 32'hFFFF_0000); m = m ^ 32'hFFFF_0000;
    rd(A_DATA, r); check("R3 toggle", r, m);

    // R4 direction
    wr(A_DIR, 32'h0F0F_0F0F);
    check("R4 pad_oe", pad_oe, 32'h0F0F_0F0F);

    // R5 pad read regardless of direction, two-flop latency
    pad_in = 32'hA5A5_5A5A;
    settle(4);
    rd(A_PAD, r); check("R5 pad read", r, 32'hA5A5_5A5A);
    pad_in = 32'h1234_0000;
    rd(A_PAD, r); check("R5 pad latency old", r, 32'hA5A5_5A5A);
    rd(A_PAD, r); check("R5 pad latency new", r, 32'h1234_0000);

    // R6 / R7 vector table
    for (int i = 0; i < 12; i++) begin
      logic [10:0] v;
      int pin;
      logic [31:0] sw;
      v   = VEC[i];
      pin = int'(v[10:6]);
      sw  = 32'(v[5:4]) << (2 * (pin % 16));
      wr(A_SLO, (pin < 16) ? sw : 32'h0);
      wr(A_SHI, (pin >= 16) ? sw : 32'h0);
      wr(A_BOTH, 32'(v[3]) << pin);
      pad_in = 32'(v[2]) << pin;
      settle(6);
      wr(A_STAT, 32'h1 << pin);
      pad_in = 32'(v[1]) << pin;
      settle(6);
      rd(A_STAT, r);
      check(v[3] ? "R7 any-edge vector" : "R6 sense vector", {31'b0, r[pin]}, {31'b0, v[0]});
    end

    // all pins rising-edge for the status tests
    wr(A_SLO, 32'hAAAA_AAAA);
    wr(A_SHI, 32'hAAAA_AAAA);
    wr(A_BOTH, 32'h0);
    pad_in = 32'h0;
    settle(6);
    wr(A_STAT, 32'hFFFF_FFFF);

    // R8 sticky, write-one-to-clear
    pad_in = 32'h0000_0018;
    settle(6);
    rd(A_STAT, r); check("R8 latched", r, 32'h0000_0018);
    wr(A_STAT, 32'h0000_0008);
    rd(A_STAT, r); check("R8 w1c partial", r, 32'h0000_0010);

    // R11 interrupt mask
    wr(A_MASK, 32'h0000_0010);
    check("R11 irq on", {31'b0, irq}, 32'h1);
    wr(A_MASK, 32'h0000_0008);
    check("R11 irq masked", {31'b0, irq}, 32'h0);
    wr(A_MASK, 32'h0000_0010);
    wr(A_STAT, 32'h0000_0010);
    check("R11 irq after clear", {31'b0, irq}, 32'h0);
    rd(A_STAT, r); check("R8 all clear", r, 32'h0);

    // R10 clear and new edge in the same cycle
    pad_in = 32'h0000_0118;
    @(negedge clk);
    wr(A_STAT, 32'h0000_0100);
    rd(A_STAT, r); check("R10 event wins", r, 32'h0000_0100);

    // R9 level held re-sets after clear
    wr(A_SLO, 32'h0000_4000);
    pad_in = 32'h0000_0080;
    settle(6);
    wr(A_STAT, 32'h0000_0080);
    rd(A_STAT, r); check("R9 level re-set", {31'b0, r[7]}, 32'h1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule